// File: doc/BRIEF.md
# Conditional-Sum Adder

This block adds two wide unsigned operands and a carry-in, producing a sum of the same width and a carry-out. It avoids any rippling carry. Every bit first forms two candidate results: one for an assumed incoming carry of zero and one for an assumed carry of one. Merge levels then join neighbouring blocks in pairs. In each pair, the lower block's carry-out under each assumption steers a multiplexer that picks one of the upper block's two candidates. The block size doubles at every level until a single full-width pair of candidates is left. The real carry-in then selects the final sum and carry-out.

The width is a parameter and must be a power of two. The default is 256. The parameter `STAGES` sets how many register banks sit between the merge levels. A value of 0 gives a purely combinational adder tuned for minimum latency. A value from 1 to log2(W)+1 gives a pipeline that accepts one operation per clock. If there are fewer banks than levels, several levels are grouped between two banks. Values above log2(W)+1 are clamped to that number.

Both edges of the block are valid/ready streams. A transfer happens on a clock edge where valid and ready are both high. The whole pipeline advances only when its output slot is empty or is being taken. While the consumer holds `out_ready` low and a result is waiting, `in_ready` is low and the waiting result stays unchanged. The block samples its operands only when the input transfers, so a source does not need to hold its data otherwise.

Top module: `condsum_adder`

## Requirements
- R1: For every delivered result, `{out_cout, out_sum}` equals `in_a + in_b + in_cin` of the matching accepted input, computed at W+1 bits, with `out_cout` as bit W.
- R2: While `rst_n` is low, and after it rises until the first input is accepted, the pipelined build holds `out_valid` low.
- R3: With `STAGES` = 0, a result is valid in the same cycle as its input: `out_valid` follows `in_valid`, and the sum follows the operands with no clock edge in between.
- R4: With `out_ready` held high, the pipelined build delivers each result exactly `STAGES` cycles after it was accepted, and it accepts one input every cycle.
- R5: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and in the next cycle `out_valid` is still high with `out_sum` and `out_cout` unchanged.
- R6: Results leave in the order their inputs were accepted, and none is lost or duplicated. The number of results in flight never exceeds `STAGES`, and the pipeline drains fully once inputs stop.
- R7: A carry that travels the full width resolves correctly. All-ones plus zero with carry-in 1 gives a zero sum with carry-out 1. All-ones plus all-ones with carry-in 1 gives an all-ones sum with carry-out 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears the valid flags |
| in_valid | input | 1 | Operands and carry-in are offered |
| in_ready | output | 1 | Block takes the offered operands at this edge |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| in_cin | input | 1 | Carry-in |
| out_valid | output | 1 | A result is offered |
| out_ready | input | 1 | Consumer takes the result at this edge |
| out_sum | output | W | Sum bits |
| out_cout | output | 1 | Carry-out |

## Verification
A wrong select in a merge multiplexer corrupts only those operand patterns whose lower-block carry reaches the affected block. For that reason the stimulus includes operands that propagate across the full width, as well as random operands. A fault like this shows up as a sum miscompare on the first affected result, `STAGES` cycles after that input was accepted. A broken valid chain or a broken stall enable shows up at once as a lost, duplicated or reordered result, or as a result that changes during a stall. The per-cycle queue model catches it on the next delivery.

// File: rtl/condsum_pkg.sv
package condsum_pkg;

  // True when a register bank follows merge level m, given the number of
  // levels and the number of banks; spreads the banks evenly over the levels.
  function automatic bit cut_after(int m, int levels, int banks);
    return ((m + 1) * banks / levels) != (m * banks / levels);
  endfunction

endpackage

// File: rtl/csa_leaf.sv
// Level 0: per-bit candidates under both carry assumptions.
module csa_leaf #(
  parameter int W = 256
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s0,
  output logic [W-1:0] s1,
  output logic [W-1:0] c0,
  output logic [W-1:0] c1
);
  assign s0 = a ^ b;
  assign s1 = ~(a ^ b);
  assign c0 = a & b;
  assign c1 = a | b;
endmodule

// File: rtl/csa_merge.sv
// One merge level: NB blocks of W/NB bits become NB/2 blocks.
module csa_merge #(
  parameter int W  = 256,
  parameter int NB = 256
) (
  input  logic [W-1:0]    s0_i,
  input  logic [W-1:0]    s1_i,
  input  logic [NB-1:0]   c0_i,
  input  logic [NB-1:0]   c1_i,
  output logic [W-1:0]    s0_o,
  output logic [W-1:0]    s1_o,
  output logic [NB/2-1:0] c0_o,
  output logic [NB/2-1:0] c1_o
);
  localparam int BS  = W / NB;
  localparam int NBO = NB / 2;

  for (genvar p = 0; p < NBO; p++) begin : g_pair
    localparam int LO = 2 * p * BS;
    localparam int HI = LO + BS;
    logic k0, k1;
    assign k0 = c0_i[2*p];
    assign k1 = c1_i[2*p];
    // lower half passes through
    assign s0_o[HI-1:LO] = s0_i[HI-1:LO];
    assign s1_o[HI-1:LO] = s1_i[HI-1:LO];
    // upper half picked by the lower half's carry for each assumption
    assign s0_o[HI+BS-1:HI] = k0 ? s1_i[HI+BS-1:HI] : s0_i[HI+BS-1:HI];
    assign s1_o[HI+BS-1:HI] = k1 ? s1_i[HI+BS-1:HI] : s0_i[HI+BS-1:HI];
    assign c0_o[p] = k0 ? c1_i[2*p+1] : c0_i[2*p+1];
    assign c1_o[p] = k1 ? c1_i[2*p+1] : c0_i[2*p+1];
  end
endmodule

// File: rtl/condsum_adder.sv
module condsum_adder #(
  parameter int W      = 256,
  parameter int STAGES = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         in_cin,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_sum,
  output logic         out_cout
);
  localparam int LOGW   = $clog2(W);
  localparam int LEVELS = LOGW + 1;
  localparam int NSTG   = (STAGES > LEVELS) ? LEVELS : STAGES;

  // whole pipeline advances when the output slot is free or being taken
  assign in_ready = !out_valid || out_ready;

  for (genvar m = 0; m < LEVELS; m++) begin : g_lvl
    localparam int NB  = W >> m;
    localparam bit CUT = condsum_pkg::cut_after(m, LEVELS, NSTG);

    logic [W-1:0]  d_s0, d_s1, q_s0, q_s1;
    logic [NB-1:0] d_c0, d_c1, q_c0, q_c1;
    logic          d_ci, q_ci, d_v, q_v;

    if (m == 0) begin : g_src
      csa_leaf #(.W(W)) u_leaf (
        .a(in_a), .b(in_b),
        .s0(d_s0), .s1(d_s1), .c0(d_c0), .c1(d_c1)
      );
      assign d_ci = in_cin;
      assign d_v  = in_valid;
    end else begin : g_mrg
      csa_merge #(.W(W), .NB(2*NB)) u_merge (
        .s0_i(g_lvl[m-1].q_s0), .s1_i(g_lvl[m-1].q_s1),
        .c0_i(g_lvl[m-1].q_c0), .c1_i(g_lvl[m-1].q_c1),
        .s0_o(d_s0), .s1_o(d_s1), .c0_o(d_c0), .c1_o(d_c1)
      );
      assign d_ci = g_lvl[m-1].q_ci;
      assign d_v  = g_lvl[m-1].q_v;
    end

    if (CUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q_v <= 1'b0;
        end else if (in_ready) begin
          q_v <= d_v;
        end
      end
      always_ff @(posedge clk) begin
        if (in_ready) begin
          q_s0 <= d_s0;
          q_s1 <= d_s1;
          q_c0 <= d_c0;
          q_c1 <= d_c1;
          q_ci <= d_ci;
        end
      end
    end else begin : g_wire
      assign q_s0 = d_s0;
      assign q_s1 = d_s1;
      assign q_c0 = d_c0;
      assign q_c1 = d_c1;
      assign q_ci = d_ci;
      assign q_v  = d_v;
    end
  end

  // final choice by the real carry-in
  assign out_valid = g_lvl[LEVELS-1].q_v;
  assign out_sum   = g_lvl[LEVELS-1].q_ci ? g_lvl[LEVELS-1].q_s1 : g_lvl[LEVELS-1].q_s0;
  assign out_cout  = g_lvl[LEVELS-1].q_ci ? g_lvl[LEVELS-1].q_c1[0] : g_lvl[LEVELS-1].q_c0[0];
endmodule

// File: rtl/condsum_adder_chk.sv
module condsum_adder_chk #(
  parameter int W      = 256,
  parameter int STAGES = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic         in_cin,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_sum,
  input logic         out_cout
);
  localparam int LEVELS = $clog2(W) + 1;
  localparam int NSTG   = (STAGES > LEVELS) ? LEVELS : STAGES;
  localparam int DEPTH  = NSTG + 1;

  logic acc, dlv;
  assign acc = in_valid && in_ready;
  assign dlv = out_valid && out_ready;

  logic [W:0] exp_res;
  int         inflight;

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= 0;
    else        inflight <= inflight + (acc ? 1 : 0) - (dlv ? 1 : 0);
  end

  if (NSTG == 0) begin : g_comb
    assign exp_res = {1'b0, in_a} + {1'b0, in_b} + {{W{1'b0}}, in_cin};
  end else begin : g_fifo
    logic [W:0] mem [DEPTH];
    int wp, rp;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp <= 0;
        rp <= 0;
      end else begin
        if (acc) begin
          mem[wp] <= {1'b0, in_a} + {1'b0, in_b} + {{W{1'b0}}, in_cin};
          wp <= (wp + 1) % DEPTH;
        end
        if (dlv) rp <= (rp + 1) % DEPTH;
      end
    end
    assign exp_res = mem[rp];
  end

  // R1 / R6: delivered result matches oldest accepted input
  a_r1_sum_matches: assert property (@(posedge clk) disable iff (!rst_n)
    dlv |-> ({out_cout, out_sum} == exp_res));

  // R6: occupancy bounded and no result without a pending input
  a_r6_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight >= 0) && (inflight <= NSTG));
  a_r6_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    (NSTG > 0 && inflight == 0) |-> !out_valid);

  // R2: valid low right after reset release
  a_r2_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (NSTG > 0 && $rose(rst_n)) |-> !out_valid);

  // R5: stalled result held and input refused
  a_r5_stall_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (NSTG > 0 && out_valid && !out_ready) |=>
      (out_valid && $stable(out_sum) && $stable(out_cout)));

  // R3: combinational build shows input validity immediately
  a_r3_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (NSTG == 0) |-> (out_valid == in_valid));
endmodule

bind condsum_adder condsum_adder_chk #(.W(W), .STAGES(STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_b(in_b), .in_cin(in_cin), .out_valid(out_valid),
  .out_ready(out_ready), .out_sum(out_sum), .out_cout(out_cout)
);

// File: tb/condsum_adder_test.sv
module condsum_adder_test;
  localparam int W   = 256;
  localparam int STG = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_cin = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0;

  logic         rdy_p, ov_p, co_p, rdy_c, ov_c, co_c;
  logic [W-1:0] sum_p, sum_c;

  condsum_adder #(.W(W), .STAGES(STG)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_p),
    .in_a(in_a), .in_b(in_b), .in_cin(in_cin), .out_valid(ov_p),
    .out_ready(out_ready), .out_sum(sum_p), .out_cout(co_p));

  condsum_adder #(.W(W), .STAGES(0)) uut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_c),
    .in_a(in_a), .in_b(in_b), .in_cin(in_cin), .out_valid(ov_c),
    .out_ready(out_ready), .out_sum(sum_c), .out_cout(co_c));

  int nvec = 0, nbad = 0, cyc = 0;
  bit lat_chk = 1'b0, done = 1'b0;
  logic [W:0] qp[$], qc[$];
  int         tp[$], tc[$];
  bit         stall_seen = 1'b0;
  logic [W:0] stall_val;

  function automatic logic [W-1:0] rnd();
    logic [W-1:0] v;
    for (int i = 0; i < W / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [W:0] act, logic [W:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic score();
    logic [W:0] e;
    int st;
    // stall continuation (R5)
    if (stall_seen)
      chk(ov_p && ({co_p, sum_p} == stall_val), "R5 hold", {co_p, sum_p}, stall_val);
    if (ov_p && !out_ready)
      chk(!rdy_p, "R5 ready", {{W{1'b0}}, rdy_p}, '0);
    // push accepted inputs
    if (in_valid && rdy_p) begin
      qp.push_back({1'b0, in_a} + {1'b0, in_b} + in_cin); tp.push_back(cyc);
    end
    if (in_valid && rdy_c) begin
      qc.push_back({1'b0, in_a} + {1'b0, in_b} + in_cin); tc.push_back(cyc);
    end
    // pop deliveries (R1, R3, R4, R6)
    if (ov_p && out_ready) begin
      if (qp.size() == 0) chk(1'b0, "R6 phantom", {co_p, sum_p}, '0);
      else begin
        e = qp.pop_front(); st = tp.pop_front();
        chk({co_p, sum_p} == e, "R1 pipelined", {co_p, sum_p}, e);
        if (lat_chk) chk(cyc - st == STG, "R4 latency", (W+1)'(cyc - st), (W+1)'(STG));
      end
    end
    if (ov_c && out_ready) begin
      if (qc.size() == 0) chk(1'b0, "R6 phantom comb", {co_c, sum_c}, '0);
      else begin
        e = qc.pop_front(); st = tc.pop_front();
        chk({co_c, sum_c} == e, "R1 comb", {co_c, sum_c}, e);
        chk(cyc == st, "R3 same cycle", (W+1)'(cyc - st), '0);
      end
    end
    chk(ov_c == in_valid, "R3 valid", {{W{1'b0}}, ov_c}, {{W{1'b0}}, in_valid});
    stall_seen = ov_p && !out_ready;
    stall_val  = {co_p, sum_p};
  endtask

  task automatic step(bit v, logic [W-1:0] a, logic [W-1:0] b, bit c, bit r);
    @(negedge clk);
    in_valid = v; in_a = a; in_b = b; in_cin = c; out_ready = r;
    #1;
    cyc++;
    score();
  endtask

  initial begin
    // R2: reset holds valid low
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!ov_p, "R2 in reset", {{W{1'b0}}, ov_p}, '0);
    end
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!ov_p, "R2 after reset", {{W{1'b0}}, ov_p}, '0);
    end

    // R7 / R4: directed full-width carry vectors, ready high
    lat_chk = 1'b1;
    step(1, '1, '0, 1, 1);
    chk({co_c, sum_c} == {1'b1, {W{1'b0}}}, "R7 ones+0+1", {co_c, sum_c}, {1'b1, {W{1'b0}}});
    step(1, '1, '1, 1, 1);
    chk({co_c, sum_c} == {1'b1, {W{1'b1}}}, "R7 ones+ones+1", {co_c, sum_c}, {1'b1, {W{1'b1}}});
    step(1, '0, '0, 0, 1);
    step(1, '0, '0, 1, 1);
    step(1, {(W/2){2'b01}}, {(W/2){2'b10}}, 1, 1);
    step(1, {1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, 0, 1);
    step(1, '1, {{(W-1){1'b0}}, 1'b1}, 0, 1);
    for (int i = 0; i < 40; i++) step(1, rnd(), rnd(), 1'($urandom), 1);
    for (int i = 0; i < STG + 2; i++) step(0, '0, '0, 0, 1);

    // random valid / ready with back-pressure
    lat_chk = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] a, b;
      a = rnd(); b = rnd();
      if (($urandom % 8) == 0) b = ~a;
      step(1'(($urandom % 4) != 0), a, b, 1'($urandom), 1'(($urandom % 3) != 0));
    end

    // R6: drain
    for (int i = 0; i < STG + 4; i++) step(0, '0, '0, 0, 1);
    chk(qp.size() == 0 && !ov_p, "R6 drained", (W+1)'(qp.size()), '0);
    chk(qc.size() == 0, "R6 drained comb", (W+1)'(qc.size()), '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule